// File: doc/BRIEF.md
# Vectored Interrupt Controller Core

This block is the local interrupt controller in front of one processor hart. It watches 48 external request lines. Each line has its own pending bit, enable bit, attribute byte and control byte. Every line can be set to capture a level, a rising edge or a falling edge. On every cycle the controller picks the enabled pending source with the highest priority. It raises a request to the hart only when that winner's priority level is strictly above a programmable machine-mode threshold. Along with the request it gives the source ID, the 8-bit level and the hardware-vector flag.

Software reaches the block through a simple write port and a combinational read port, both word-addressed. Each write carries four byte strobes, so any single byte of a per-source word can be written alone. The read-only words report the capability flag, the source count, the number of implemented priority bits and a version byte. When the hart takes an edge-triggered interrupt, it returns that source's ID on the acknowledge input, and this clears the pending bit.

Address map (word addresses, `ADDR_W` = 7): word 0 holds the configuration. Word 1 holds the info value. Word 2 holds the threshold. Words 64+i hold the register word for source i. Every other address reads as zero.

Top module: `vic_core`

## Requirements
- R1: After reset, `req_o` is 0 and the threshold reads 0. Every source word reads 0x1FC00000: pending 0, enable 0, trigger 00, vector flag 0, mode bits [23:22] = 11, and control byte 0x1F.
- R2: The configuration word reads 0x00000001, with the vector capability flag in bit 0. The info word reads the source count in [12:0], the version byte (default 0x21) in [20:13] and the number of implemented priority bits (3) in [24:21]. Writes to either word have no effect.
- R3: Within a source word, bit 0 is pending, bit 8 is enable, byte 2 holds the attributes and byte 3 holds the control byte. A write changes only the bytes whose strobe is set.
- R4: In the attribute byte, bit 0 is the vector flag and bits [2:1] are the trigger. Bits [7:6] always read 11 and cannot be written. A trigger with bit 0 = 0 (00 or 10) selects level, 01 selects rising edge, and 11 selects falling edge.
- R5: For a level source, pending follows the input three clock edges after it changes (two synchronizer stages plus the pending register). Software writes to the pending bit are ignored.
- R6: For a rising-edge source, a 0→1 input transition sets pending three edges later. Pending then stays set after the input falls.
- R7: For a falling-edge source, a 1→0 input transition sets pending. A steady high input does not set it.
- R8: For an edge source, a write with bit 0 = 0 clears pending, and so does an acknowledge whose ID matches the source. An acknowledge for any other ID has no effect. If a new edge arrives in the same cycle as a clear, the edge wins and pending stays 1.
- R9: Only control bits [7:5] are stored. Bits [4:0] read back as 1s, so the effective level is {ctl[7:5], 5'b11111}.
- R10: The winner is the enabled pending source with the largest level, and a tie goes to the highest source ID. Sources that are disabled or not pending never win.
- R11: `req_o` is 1 only when the winner's level is strictly greater than the threshold, which is byte 3 of word 2.
- R12: The result is registered. `req_o`, `req_id_o`, `req_lvl_o` and `req_shv_o` change one edge after pending and enable settle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 48 | Raw interrupt request lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 7 | Write word address |
| wr_be_i | input | 4 | Write byte strobes |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 7 | Read word address |
| rd_data_o | output | 32 | Read data (combinational) |
| ack_i | input | 1 | Acknowledge strobe from the hart |
| ack_id_i | input | 6 | ID of the acknowledged source |
| req_o | output | 1 | Interrupt request to the hart |
| req_id_o | output | 6 | Winning source ID |
| req_lvl_o | output | 8 | Winning level |
| req_shv_o | output | 1 | Winning source's hardware-vector flag |

## Verification
The risky overlap is an edge capture and a pending clear landing in the same cycle, where the clear is either an acknowledge or a software write of zero. The bench first sets pending on an edge source by software. It then drops the line and raises it again. It times the acknowledge for that source so it arrives on exactly the third edge after the rise, which is the edge where the synchronized transition is captured. Pending must still read 1 afterwards; a design that let the clear win would read 0.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int CTL_W   = 8;
  localparam int WORD_W  = 32;
  localparam int REG_CFG  = 0;
  localparam int REG_INFO = 1;
  localparam int REG_THR  = 2;
  localparam logic [1:0] MODE_MACHINE = 2'b11;

  typedef enum logic [1:0] {TRG_LEVEL, TRG_RISE, TRG_FALL} trg_kind_e;

  function automatic trg_kind_e decode_trig(input logic [1:0] t);
    if (!t[0])     return TRG_LEVEL;
    else if (!t[1]) return TRG_RISE;
    else            return TRG_FALL;
  endfunction
endpackage

// File: rtl/vic_src.sv
module vic_src
  import vic_pkg::*;
#(
  parameter int ID     = 0,
  parameter int ID_W   = 6,
  parameter int PRIO_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_be_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              ack_i,
  input  logic [ID_W-1:0]   ack_id_i,
  output logic              pend_o,
  output logic              en_o,
  output logic              shv_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int PAD_W = CTL_W - PRIO_W;

  logic s1_q, s2_q, s3_q;
  logic pend_q, en_q, shv_q;
  logic [1:0] trig_q;
  logic [PRIO_W-1:0] prio_q;
  trg_kind_e kind;
  logic edge_hit, ack_hit, sw_pend, pend_d;
  logic unused_wd;

  assign unused_wd = ^wr_data_i;
  assign kind      = decode_trig(trig_q);
  assign ack_hit   = ack_i && (ack_id_i == ID_W'(ID));
  assign sw_pend   = wr_en_i && wr_be_i[0];

  always_comb begin
    case (kind)
      TRG_RISE: edge_hit = s2_q & ~s3_q;
      TRG_FALL: edge_hit = ~s2_q & s3_q;
      default:  edge_hit = 1'b0;
    endcase
  end

  // edge capture wins over any clear in the same cycle
  always_comb begin
    if (kind == TRG_LEVEL) pend_d = s2_q;
    else if (edge_hit)     pend_d = 1'b1;
    else if (ack_hit)      pend_d = 1'b0;
    else if (sw_pend)      pend_d = wr_data_i[0];
    else                   pend_d = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      shv_q  <= 1'b0;
      trig_q <= 2'b00;
      prio_q <= '0;
    end else begin
      s1_q   <= irq_i;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      pend_q <= pend_d;
      if (wr_en_i && wr_be_i[1]) en_q <= wr_data_i[8];
      if (wr_en_i && wr_be_i[2]) begin
        shv_q  <= wr_data_i[16];
        trig_q <= wr_data_i[18:17];
      end
      if (wr_en_i && wr_be_i[3]) prio_q <= wr_data_i[WORD_W-1 -: PRIO_W];
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign shv_o  = shv_q;
  assign prio_o = prio_q;
  assign word_o = {prio_q, {PAD_W{1'b1}}, MODE_MACHINE, 3'b000, trig_q, shv_q,
                   7'b0, en_q, 7'b0, pend_q};

  assert_level_mirror_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(trig_q[0] == 1'b0) |-> (pend_q == $past(s2_q)));

  assert_edge_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q[0] && edge_hit) |=> pend_q);

  assert_edge_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q[0] && pend_q && !ack_hit && !(sw_pend && !wr_data_i[0])) |=> pend_q);
endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
  parameter int N_SRC  = 48,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 6
) (
  input  logic [N_SRC-1:0]             cand_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [N_SRC-1:0]             shv_i,
  output logic                         hit_o,
  output logic [ID_W-1:0]              id_o,
  output logic [PRIO_W-1:0]            prio_o,
  output logic                         shv_o
);
  logic              hit;
  logic [ID_W-1:0]   id;
  logic [PRIO_W-1:0] prio;
  logic              shv;

  // ascending scan with >= : ties resolve to the highest ID
  always_comb begin
    hit  = 1'b0;
    id   = '0;
    prio = '0;
    shv  = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (cand_i[i] && (!hit || prio_i[i] >= prio)) begin
        hit  = 1'b1;
        id   = ID_W'(i);
        prio = prio_i[i];
        shv  = shv_i[i];
      end
    end
  end

  assign hit_o  = hit;
  assign id_o   = id;
  assign prio_o = prio;
  assign shv_o  = shv;
endmodule

// File: rtl/vic_core.sv
module vic_core
  import vic_pkg::*;
#(
  parameter int         N_SRC   = 48,
  parameter int         PRIO_W  = 3,
  parameter int         ADDR_W  = 7,
  parameter logic [7:0] VERSION = 8'h21,
  localparam int        ID_W    = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [3:0]        wr_be_i,
  input  logic [31:0]       wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  input  logic              ack_i,
  input  logic [ID_W-1:0]   ack_id_i,
  output logic              req_o,
  output logic [ID_W-1:0]   req_id_o,
  output logic [CTL_W-1:0]  req_lvl_o,
  output logic              req_shv_o
);
  localparam int LVL_PAD = CTL_W - PRIO_W;

  logic [N_SRC-1:0]             pend_vec, en_vec, shv_vec;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_arr;
  logic [WORD_W-1:0]            src_word [N_SRC];
  logic                         wr_src;

  logic              arb_hit, arb_shv;
  logic [ID_W-1:0]   arb_id;
  logic [PRIO_W-1:0] arb_prio;
  logic [CTL_W-1:0]  arb_lvl;

  logic [CTL_W-1:0]  thresh_q, lvl_q;
  logic              req_q, shv_q;
  logic [ID_W-1:0]   id_q;
  logic [ID_W-1:0]   rd_idx;

  assign wr_src = wr_en_i && wr_addr_i[ADDR_W-1];

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    vic_src #(.ID(g), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_src (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .irq_i     (irq_i[g]),
      .wr_en_i   (wr_src && (wr_addr_i[ID_W-1:0] == ID_W'(g))),
      .wr_be_i   (wr_be_i),
      .wr_data_i (wr_data_i),
      .ack_i     (ack_i),
      .ack_id_i  (ack_id_i),
      .pend_o    (pend_vec[g]),
      .en_o      (en_vec[g]),
      .shv_o     (shv_vec[g]),
      .prio_o    (prio_arr[g]),
      .word_o    (src_word[g])
    );
  end

  vic_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
    .cand_i (pend_vec & en_vec),
    .prio_i (prio_arr),
    .shv_i  (shv_vec),
    .hit_o  (arb_hit),
    .id_o   (arb_id),
    .prio_o (arb_prio),
    .shv_o  (arb_shv)
  );

  assign arb_lvl = {arb_prio, {LVL_PAD{1'b1}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thresh_q <= '0;
      req_q    <= 1'b0;
      id_q     <= '0;
      lvl_q    <= '0;
      shv_q    <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == ADDR_W'(REG_THR) && wr_be_i[3])
        thresh_q <= wr_data_i[31:24];
      req_q <= arb_hit && (arb_lvl > thresh_q);
      id_q  <= arb_id;
      lvl_q <= arb_lvl;
      shv_q <= arb_shv;
    end
  end

  assign req_o     = req_q;
  assign req_id_o  = id_q;
  assign req_lvl_o = lvl_q;
  assign req_shv_o = shv_q;

  assign rd_idx = rd_addr_i[ID_W-1:0];

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i[ADDR_W-1]) begin
      if ({1'b0, rd_idx} < (ID_W+1)'(N_SRC)) rd_data_o = src_word[rd_idx];
    end else if (rd_addr_i == ADDR_W'(REG_CFG)) begin
      rd_data_o = 32'h0000_0001;
    end else if (rd_addr_i == ADDR_W'(REG_INFO)) begin
      rd_data_o = {7'b0, 4'(PRIO_W), VERSION, 13'(N_SRC)};
    end else if (rd_addr_i == ADDR_W'(REG_THR)) begin
      rd_data_o = {thresh_q, 24'b0};
    end
  end

  assert_req_above_thresh_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (req_lvl_o > $past(thresh_q)));

  assert_req_has_cand_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(|(pend_vec & en_vec)));
endmodule

// File: tb/tb_vic_core.sv
`timescale 1ns/1ps
module tb_vic_core;
  localparam int N = 48;
  localparam int SB = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        ack = 1'b0;
  logic [5:0]  ack_id = '0;
  logic        req;
  logic [5:0]  req_id;
  logic [7:0]  req_lvl;
  logic        req_shv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int mprio [N];
  bit men [N];
  bit mshv [N];

  always #4 clk = ~clk;

  vic_core dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_be_i(wr_be), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .ack_i(ack), .ack_id_i(ack_id),
    .req_o(req), .req_id_o(req_id), .req_lvl_o(req_lvl), .req_shv_o(req_shv)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", rq, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 7'(a); wr_be = be; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_addr = 7'(a);
    #1;
    d = rd_data;
  endtask

  task automatic do_ack(input int id);
    ack = 1'b1; ack_id = 6'(id);
    step(1);
    ack = 1'b0;
  endtask

  function automatic logic [7:0] lvl_of(input int p);
    return {3'(p), 5'b11111};
  endfunction

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2718));
    step(3);
    rst_n = 1'b1;
    step(1);

    // reset state
    chk("R1 req after reset", {31'b0, req}, 32'h0);
    rd(2, d);  chk("R1 threshold reset", d, 32'h0);
    rd(SB, d); chk("R1 source word reset", d, 32'h1FC0_0000);
    rd(SB + 47, d); chk("R1 last source word reset", d, 32'h1FC0_0000);
    rd(0, d);  chk("R2 config word", d, 32'h1);
    rd(1, d);  chk("R2 info word", d, (32'd3 << 21) | (32'h21 << 13) | 32'd48);
    wr(1, 4'b1111, 32'hFFFF_FFFF);
    wr(0, 4'b1111, 32'h0);
    rd(1, d);  chk("R2 info write ignored", d, (32'd3 << 21) | (32'h21 << 13) | 32'd48);
    rd(0, d);  chk("R2 config write ignored", d, 32'h1);

    // byte strobes, attribute and control fields on source 7
    wr(SB + 7, 4'b0010, 32'hFFFF_FFFF);
    rd(SB + 7, d); chk("R3 enable byte alone", d, 32'h1FC0_0100);
    wr(SB + 7, 4'b0100, 32'hFFFF_FFFF);
    rd(SB + 7, d); chk("R4 attr write, mode fixed", d, 32'h1FC7_0100);
    wr(SB + 7, 4'b1000, 32'hA000_0000);
    rd(SB + 7, d); chk("R9 control low bits read 1", d, 32'hBFC7_0100);
    wr(SB + 7, 4'b1110, 32'h0);
    rd(SB + 7, d); chk("R3 restore source 7", d, 32'h1FC0_0000);

    // level source 5
    irq[5] = 1'b1; step(2);
    rd(SB + 5, d); chk("R5 level not yet seen", {31'b0, d[0]}, 32'h0);
    step(1);
    rd(SB + 5, d); chk("R5 level pending after 3 edges", {31'b0, d[0]}, 32'h1);
    wr(SB + 5, 4'b0001, 32'h0);
    rd(SB + 5, d); chk("R5 write to level pending ignored", {31'b0, d[0]}, 32'h1);
    irq[5] = 1'b0; step(4);
    rd(SB + 5, d); chk("R5 level pending follows low", {31'b0, d[0]}, 32'h0);
    irq[5] = 1'b1; step(4);

    // latency of request
    wr(SB + 5, 4'b1000, 32'h4000_0000);
    wr(SB + 5, 4'b0010, 32'h0000_0100);
    chk("R12 no request on enable edge", {31'b0, req}, 32'h0);
    step(1);
    chk("R12 request one edge later", {31'b0, req}, 32'h1);
    chk("R12 winner id", {26'b0, req_id}, 32'd5);
    chk("R12 winner level", {24'b0, req_lvl}, 32'h5F);
    chk("R12 winner vector flag", {31'b0, req_shv}, 32'h0);

    // threshold
    wr(2, 4'b1000, 32'h5F00_0000); step(1);
    chk("R11 level equal to threshold blocked", {31'b0, req}, 32'h0);
    wr(2, 4'b1000, 32'h5E00_0000); step(1);
    chk("R11 level above threshold passes", {31'b0, req}, 32'h1);
    wr(2, 4'b0111, 32'h00FF_FFFF); step(1);
    rd(2, d); chk("R11 threshold byte strobe", d, 32'h5E00_0000);
    wr(2, 4'b1000, 32'h0);

    // arbitration
    wr(SB + 9, 4'b1000, 32'h4000_0000);
    wr(SB + 9, 4'b0010, 32'h0000_0100);
    irq[9] = 1'b1; step(5);
    chk("R10 tie goes to higher id", {26'b0, req_id}, 32'd9);
    wr(SB + 3, 4'b1110, 32'h6001_0100);
    irq[3] = 1'b1; step(5);
    chk("R10 higher level wins", {26'b0, req_id}, 32'd3);
    chk("R10 winner level", {24'b0, req_lvl}, 32'h7F);
    chk("R10 winner vector flag", {31'b0, req_shv}, 32'h1);
    wr(SB + 40, 4'b1000, 32'hE000_0000);
    irq[40] = 1'b1; step(5);
    chk("R10 disabled source ignored", {26'b0, req_id}, 32'd3);
    wr(SB + 3, 4'b0110, 32'h0);
    wr(SB + 5, 4'b0010, 32'h0);
    wr(SB + 9, 4'b0010, 32'h0);
    irq = '0; step(5);
    chk("R10 nothing enabled, no request", {31'b0, req}, 32'h0);

    // trigger 10 is level
    wr(SB + 22, 4'b0100, 32'h0004_0000);
    irq[22] = 1'b1; step(4);
    rd(SB + 22, d); chk("R4 trigger 10 level high", {31'b0, d[0]}, 32'h1);
    irq[22] = 1'b0; step(4);
    rd(SB + 22, d); chk("R4 trigger 10 level low", {31'b0, d[0]}, 32'h0);

    // rising edge source 20
    wr(SB + 20, 4'b0100, 32'h0002_0000);
    irq[20] = 1'b1; step(3);
    rd(SB + 20, d); chk("R6 rising edge sets pending", {31'b0, d[0]}, 32'h1);
    irq[20] = 1'b0; step(4);
    rd(SB + 20, d); chk("R6 pending held after fall", {31'b0, d[0]}, 32'h1);
    wr(SB + 20, 4'b0001, 32'h0);
    rd(SB + 20, d); chk("R8 write 0 clears edge pending", {31'b0, d[0]}, 32'h0);
    irq[20] = 1'b1; step(3);
    do_ack(21);
    rd(SB + 20, d); chk("R8 other id ack ignored", {31'b0, d[0]}, 32'h1);
    do_ack(20);
    rd(SB + 20, d); chk("R8 matching ack clears", {31'b0, d[0]}, 32'h0);
    step(3);
    rd(SB + 20, d); chk("R6 steady high no re-set", {31'b0, d[0]}, 32'h0);
    // edge and clear in the same cycle
    irq[20] = 1'b0; step(3);
    wr(SB + 20, 4'b0001, 32'h1);
    irq[20] = 1'b1; step(2);
    do_ack(20);
    rd(SB + 20, d); chk("R8 edge wins over ack", {31'b0, d[0]}, 32'h1);
    irq[20] = 1'b0; step(3);
    irq[20] = 1'b1; step(2);
    wr(SB + 20, 4'b0001, 32'h0);
    rd(SB + 20, d); chk("R8 edge wins over write 0", {31'b0, d[0]}, 32'h1);
    wr(SB + 20, 4'b0001, 32'h0);
    irq[20] = 1'b0;

    // falling edge source 21
    irq[21] = 1'b1; step(4);
    wr(SB + 21, 4'b0100, 32'h0006_0000);
    wr(SB + 21, 4'b0001, 32'h0);
    step(3);
    rd(SB + 21, d); chk("R7 steady high does not set", {31'b0, d[0]}, 32'h0);
    irq[21] = 1'b0; step(3);
    rd(SB + 21, d); chk("R7 falling edge sets pending", {31'b0, d[0]}, 32'h1);
    wr(SB + 21, 4'b0101, 32'h0);
    wr(SB + 22, 4'b0100, 32'h0);
    step(5);

    // random arbitration against the model, all sources level
    for (int it = 0; it < 40; it++) begin
      logic [7:0] thr;
      bit found;
      int best, bid;
      logic [7:0] elvl;
      bit ereq;
      for (int i = 0; i < N; i++) begin
        mprio[i] = int'($urandom_range(0, 7));
        men[i]   = 1'($urandom_range(0, 1));
        mshv[i]  = 1'($urandom_range(0, 1));
        wr(SB + i, 4'b1110, {3'(mprio[i]), 5'b0, 7'b0, mshv[i], 7'b0, men[i], 8'h00});
      end
      thr = (it % 3 == 0) ? 8'h00 : 8'($urandom_range(0, 255));
      wr(2, 4'b1000, {thr, 24'b0});
      irq = {16'($urandom), 32'($urandom)};
      if (it % 5 == 4) irq = '0;
      step(6);
      found = 1'b0; best = 0; bid = 0;
      for (int i = 0; i < N; i++) begin
        if (irq[i] && men[i] && (!found || mprio[i] >= best)) begin
          found = 1'b1; best = mprio[i]; bid = i;
        end
      end
      elvl = lvl_of(best);
      ereq = found && (elvl > thr);
      chk("R11 random request", {31'b0, req}, {31'b0, ereq});
      if (ereq) begin
        chk("R10 random winner id", {26'b0, req_id}, 32'(bid));
        chk("R10 random winner level", {24'b0, req_lvl}, {24'b0, elvl});
        chk("R12 random vector flag", {31'b0, req_shv}, {31'b0, mshv[bid]});
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule